// File: doc/BRIEF.md
# Shared Buffer Cycle Arbiter

This block shares one external buffer memory between two requesters: a peripheral controller that runs on the chip clock, and the SCSI DMA engine, whose request arrives without a timing relation to that clock. The arbiter grants the memory one cycle at a time. Each cycle has a fixed length and ends with a one-clock acknowledge to the requester that won it. While both sides keep asking, their cycles alternate.

The peripheral request is active low and is captured on the falling clock edge. The SCSI request passes through a chain of rising-edge synchronizer flops before the arbiter uses it. DMA enable gates every new grant. A cycle that has started always runs to its end, whatever happens to the requests, to DMA enable or to the direction input. The direction sampled when a cycle starts sets what the memory does. In send direction the buffer is read at the read pointer. In receive direction the buffer is written at the write pointer.

Top module: `buf_arbiter`

## Requirements
- R1: After reset, all grants, acknowledges, memory strobes and the address select are low.
- R2: `ext_req_n` is captured on the falling clock edge. For a peripheral request on its own, driven low between a rising edge and the next falling edge, the peripheral grant is high right after the next rising edge.
- R3: `scsi_drq` passes through SYNC_STAGES rising-edge flops. For a SCSI request on its own, the SCSI grant is high right after the (SYNC_STAGES+1)-th rising edge that follows the input change.
- R4: Every grant stays high for exactly CYC_LEN clock cycles. It is followed by exactly one cycle of acknowledge to the same requester, and that acknowledge is not repeated.
- R5: When both requests are pending at a decision, and either the last cycle served SCSI or nothing has been served since reset, the peripheral wins.
- R6: When both requests are pending and the last cycle served the peripheral, SCSI wins. While both sides keep asking, the cycles alternate peripheral, SCSI, peripheral, SCSI.
- R7: A cycle in progress is never cut short or handed to the other requester.
- R8: While `dma_en` is low no new grant starts. A cycle already running when `dma_en` falls still completes.
- R9: During a grant with `dir_send`=1 captured at cycle start, `mem_rd`=1, `mem_wr`=0 and `sel_wap`=0 (read pointer). With `dir_send`=0, `mem_wr`=1, `mem_rd`=0 and `sel_wap`=1 (write pointer). Changing `dir_send` during the cycle has no effect. Outside grants all three are 0.
- R10: After a SCSI grant, the next SCSI grant needs the synchronized request to have been seen low first. A request held high continuously gets only one cycle.
- R11: The two grants are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req_n | input | 1 | Peripheral request, active low, synchronous |
| scsi_drq | input | 1 | SCSI DMA request, asynchronous |
| dma_en | input | 1 | Allows new grants when high |
| dir_send | input | 1 | 1 = send (buffer read), 0 = receive (buffer write) |
| per_gnt | output | 1 | Memory cycle granted to the peripheral |
| scsi_gnt | output | 1 | Memory cycle granted to SCSI |
| per_ack | output | 1 | One-cycle acknowledge to the peripheral |
| scsi_ack | output | 1 | One-cycle acknowledge to SCSI |
| mem_rd | output | 1 | Buffer read strobe |
| mem_wr | output | 1 | Buffer write strobe |
| sel_wap | output | 1 | Address select: 0 = read pointer, 1 = write pointer |

## Verification
The bench first sends each requester alone, in both directions. This measures the separate latencies of the falling-edge capture and the synchronizer chain, and it checks the strobe and select pairing. Both requests are then held while DMA enable is low and released together. That shows the gate, the peripheral win on a tie and the strict alternation that follows. A SCSI request held high across its acknowledge separates a re-armed request from a stale one. Dropping DMA enable and flipping direction in the middle of a cycle shows that a running cycle cannot be disturbed.

// File: rtl/buf_arb_pkg.sv
`timescale 1ns/1ps
package buf_arb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GNT  = 2'd1,
    ST_ACK  = 2'd2
  } arb_state_t;

  typedef enum logic {
    SRC_PER  = 1'b0,
    SRC_SCSI = 1'b1
  } src_t;

  // Winner of a decision: the peripheral takes ties unless it had the last cycle.
  function automatic src_t pick_src(input logic per_p, input logic scsi_p, input src_t last_src);
    if (per_p && scsi_p)
      return (last_src == SRC_PER) ? SRC_SCSI : SRC_PER;
    else if (per_p)
      return SRC_PER;
    else
      return SRC_SCSI;
  endfunction

  // Memory controls {sel_wap, mem_wr, mem_rd} for an active cycle and its direction.
  function automatic logic [2:0] mem_ctl(input logic active, input logic send);
    if (!active)
      return 3'b000;
    return send ? 3'b001 : 3'b110;
  endfunction

endpackage

// File: rtl/arb_ext_capture.sv
`timescale 1ns/1ps
module arb_ext_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n,
  output logic req
);
  // Peripheral request captured on the falling edge, active-high inside.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else        req <= ~req_n;
  end
endmodule

// File: rtl/arb_drq_sync.sv
`timescale 1ns/1ps
module arb_drq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= d_async;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/arb_cyc_timer.sv
`timescale 1ns/1ps
module arb_cyc_timer #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST_VAL = CW'(LEN - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (!last) cnt <= cnt + 1'b1;
    else           cnt <= '0;
  end

  assign last = run && (cnt == LAST_VAL);

  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST_VAL);
  a_r4_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
endmodule

// File: rtl/buf_arbiter.sv
`timescale 1ns/1ps
module buf_arbiter
  import buf_arb_pkg::*;
#(
  parameter int CYC_LEN     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_req_n,
  input  logic scsi_drq,
  input  logic dma_en,
  input  logic dir_send,
  output logic per_gnt,
  output logic scsi_gnt,
  output logic per_ack,
  output logic scsi_ack,
  output logic mem_rd,
  output logic mem_wr,
  output logic sel_wap
);
  arb_state_t state;
  src_t       owner;
  src_t       last_src;
  src_t       win;
  logic       cyc_send;
  logic       per_req;
  logic       scsi_req_s;
  logic       scsi_armed;
  logic       per_pend;
  logic       scsi_pend;
  logic       gnt_start;
  logic       cyc_last;
  logic       in_gnt;

  arb_ext_capture u_ext (
    .clk   (clk),
    .rst_n (rst_n),
    .req_n (ext_req_n),
    .req   (per_req)
  );

  arb_drq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (scsi_drq),
    .q       (scsi_req_s)
  );

  arb_cyc_timer #(.LEN(CYC_LEN)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (in_gnt),
    .last  (cyc_last)
  );

  // Named decision events
  assign per_pend  = per_req;
  assign scsi_pend = scsi_req_s && scsi_armed;
  assign win       = pick_src(per_pend, scsi_pend, last_src);
  assign gnt_start = (state == ST_IDLE) && dma_en && (per_pend || scsi_pend);
  assign in_gnt    = (state == ST_GNT);

  // A SCSI request must be seen low after its grant before it counts again.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              scsi_armed <= 1'b1;
    else if (gnt_start && (win == SRC_SCSI)) scsi_armed <= 1'b0;
    else if (!scsi_req_s)                    scsi_armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      owner    <= SRC_PER;
      last_src <= SRC_SCSI;
      cyc_send <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (gnt_start) begin
          state    <= ST_GNT;
          owner    <= win;
          last_src <= win;
          cyc_send <= dir_send;
        end
        ST_GNT:  if (cyc_last) state <= ST_ACK;
        ST_ACK:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign per_gnt  = in_gnt && (owner == SRC_PER);
  assign scsi_gnt = in_gnt && (owner == SRC_SCSI);
  assign per_ack  = (state == ST_ACK) && (owner == SRC_PER);
  assign scsi_ack = (state == ST_ACK) && (owner == SRC_SCSI);
  assign {sel_wap, mem_wr, mem_rd} = mem_ctl(in_gnt, cyc_send);

  // R8: a grant only rises after DMA enable was sampled high
  a_r8_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(per_gnt || scsi_gnt) |-> $past(dma_en));
  // R5: tie goes to the peripheral after a SCSI cycle
  a_r5_tie_peripheral: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_start && per_pend && scsi_pend && last_src == SRC_SCSI) |=> per_gnt);
  // R6: alternation after a peripheral cycle
  a_r6_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_start && per_pend && scsi_pend && last_src == SRC_PER) |=> scsi_gnt);
  // R7: no preemption
  a_r7_per_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (per_gnt && !cyc_last) |=> per_gnt);
  a_r7_scsi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (scsi_gnt && !cyc_last) |=> scsi_gnt);
  // R4: acknowledge follows the grant for one cycle
  a_r4_per_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(per_gnt) |-> per_ack);
  a_r4_scsi_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scsi_gnt) |-> scsi_ack);
  a_r4_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    (per_ack || scsi_ack) |=> !(per_ack || scsi_ack));
  // R9: strobes and select tied to the grant
  a_r9_strobe_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (per_gnt || scsi_gnt) |-> ((mem_rd != mem_wr) && (sel_wap == mem_wr)));
  a_r9_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(per_gnt || scsi_gnt) |-> !(mem_rd || mem_wr || sel_wap));
  a_r9_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (in_gnt && !cyc_last) |=> $stable(mem_rd));
  // R11: exclusive grants
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({per_gnt, scsi_gnt, per_ack, scsi_ack}));
endmodule

// File: tb/buf_arbiter_tb.sv
`timescale 1ns/1ps
module buf_arbiter_tb;
  localparam int CYC  = 4;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n, ext_req_n, scsi_drq, dma_en, dir_send;
  logic per_gnt, scsi_gnt, per_ack, scsi_ack, mem_rd, mem_wr, sel_wap;
  int total = 0, bad = 0, excl_bad = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  buf_arbiter #(.CYC_LEN(CYC), .SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_req_n(ext_req_n), .scsi_drq(scsi_drq),
    .dma_en(dma_en), .dir_send(dir_send), .per_gnt(per_gnt), .scsi_gnt(scsi_gnt),
    .per_ack(per_ack), .scsi_ack(scsi_ack), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .sel_wap(sel_wap)
  );

  task automatic tick();
    @(posedge clk); #1;
    if (per_gnt && scsi_gnt) excl_bad++;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One isolated request: latency, length, strobes, acknowledge
  task automatic run_single(input bit is_per, input bit send);
    int lat, len, exp_lat;
    bit strobe_ok;
    dir_send = send;
    dma_en   = 1'b1;
    if (is_per) ext_req_n = 1'b0; else scsi_drq = 1'b1;
    exp_lat = is_per ? 1 : SYNC + 1;
    lat = 0;
    do begin tick(); lat++; end while (!(per_gnt || scsi_gnt) && lat < 40);
    chk(lat == exp_lat, is_per ? "R2 latency" : "R3 latency", lat, exp_lat);
    chk(is_per ? per_gnt : scsi_gnt, is_per ? "R2 owner" : "R3 owner", int'(scsi_gnt), int'(!is_per));
    len = 0;
    strobe_ok = 1;
    while ((per_gnt || scsi_gnt) && len < 40) begin
      if (mem_rd != send || mem_wr != !send || sel_wap != !send) strobe_ok = 0;
      len++;
      tick();
    end
    chk(len == CYC, "R4 grant length", len, CYC);
    chk(strobe_ok, "R9 strobes in grant", int'(strobe_ok), 1);
    chk(is_per ? (per_ack && !scsi_ack) : (scsi_ack && !per_ack), "R4 ack owner",
        {per_ack, scsi_ack}, is_per ? 2 : 1);
    chk(!mem_rd && !mem_wr && !sel_wap, "R9 idle strobes", {sel_wap, mem_wr, mem_rd}, 0);
    if (is_per) ext_req_n = 1'b1; else scsi_drq = 1'b0;
    tick();
    chk(!per_ack && !scsi_ack, "R4 single ack", {per_ack, scsi_ack}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n, cnt, glen, len, per_left, scsi_left;
    int seq[8];
    bit seen, rd_held;
    rst_n = 0; ext_req_n = 1; scsi_drq = 0; dma_en = 0; dir_send = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk({per_gnt, scsi_gnt, per_ack, scsi_ack, mem_rd, mem_wr, sel_wap} == 0,
        "R1 reset outputs", {per_gnt, scsi_gnt, per_ack, scsi_ack, mem_rd, mem_wr, sel_wap}, 0);

    // Isolated requests, both directions, SCSI last
    for (int s = 0; s < 2; s++) begin
      run_single(1'b1, s[0]);
      repeat (8) tick();
      run_single(1'b0, s[0]);
      repeat (8) tick();
    end

    // R10: request held high across its acknowledge gets one cycle only
    dir_send = 1; scsi_drq = 1;
    n = 0;
    while (!scsi_ack && n < 40) begin tick(); n++; end
    cnt = 0;
    repeat (20) begin tick(); if (scsi_gnt) cnt++; end
    chk(cnt == 0, "R10 stale request", cnt, 0);
    scsi_drq = 0;
    repeat (4) tick();
    scsi_drq = 1;
    seen = 0;
    repeat (20) begin tick(); if (scsi_gnt) seen = 1; end
    chk(seen, "R10 rearmed request", int'(seen), 1);
    scsi_drq = 0;
    repeat (8) tick();

    // R8 gate, then R5 tie and R6 alternation
    dma_en = 0; ext_req_n = 0; scsi_drq = 1;
    cnt = 0;
    repeat (8) begin tick(); if (per_gnt || scsi_gnt) cnt++; end
    chk(cnt == 0, "R8 gated grants", cnt, 0);
    dma_en = 1;
    per_left = 4; scsi_left = 4; n = 0; glen = 0;
    for (int t = 0; t < 400 && n < 8; t++) begin
      tick();
      if (per_gnt || scsi_gnt) glen++;
      else if (glen != 0) begin
        chk(glen == CYC, "R7 full cycle", glen, CYC);
        glen = 0;
      end
      if (per_ack) begin
        seq[n] = 0; n++;
        per_left--;
        if (per_left == 0) ext_req_n = 1;
      end
      if (scsi_ack) begin
        seq[n] = 1; n++;
        scsi_left--;
        scsi_drq = 0;
      end else if (!scsi_drq && scsi_left > 0) scsi_drq = 1;
    end
    chk(n == 8, "R6 cycle count", n, 8);
    chk(seq[0] == 0, "R5 tie winner", seq[0], 0);
    for (int i = 1; i < 8; i++) chk(seq[i] == (i % 2), "R6 alternation", seq[i], i % 2);
    repeat (8) tick();

    // R8 and R9: enable and direction change inside a running cycle
    dir_send = 1; dma_en = 1; ext_req_n = 0;
    n = 0;
    while (!per_gnt && n < 40) begin tick(); n++; end
    dma_en = 0; dir_send = 0;
    len = 0; rd_held = 1;
    while (per_gnt && len < 40) begin
      if (!mem_rd || mem_wr || sel_wap) rd_held = 0;
      len++;
      tick();
    end
    chk(len == CYC, "R8 cycle completes", len, CYC);
    chk(rd_held, "R9 direction captured", int'(rd_held), 1);
    chk(per_ack, "R8 ack after disable", int'(per_ack), 1);
    cnt = 0;
    repeat (10) begin tick(); if (per_gnt || scsi_gnt) cnt++; end
    chk(cnt == 0, "R8 no grant while disabled", cnt, 0);
    ext_req_n = 1;
    tick();

    chk(excl_bad == 0, "R11 exclusive grants", excl_bad, 0);
    done_flag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule